// File: doc/BRIEF.md
# Systolic Scanline Pixel Cell Array

The block turns a stream of span commands into one display row of pixels. It is a left-to-right chain of identical cells, with one cell for each pixel column. Commands enter only at the left-most cell. Every cell acts on a command in the cycle it receives it and hands the command to its right-hand neighbour one cycle later. A paint command names a column range, a colour for its first column and a per-column colour step. Each covered cell loads its own colour. That colour is built up by adding the step once in every cell the command passes from the first column onward, so no cell needs a multiplier.

Between the commands of two rows, a refresh command is sent down the chain. As it reaches each cell, that cell places its colour on the single pixel output and returns to black. Pixels therefore leave in column order, one per cycle, starting the cycle after the refresh is taken. Refreshes must be at least one row length apart. The command that falls off the right end of the chain is available on a tail port, so a further chain could be cascaded after this one.

Top module: `scan_pixel_array`

## Requirements
- R1: After reset, pix_valid and tail_valid are low and every cell holds colour zero, so a refresh before any paint emits NUM_CELLS zero pixels.
- R2: A command sampled at clock edge k acts in cell x at edge k+x and appears on the tail outputs after edge k+NUM_CELLS-1.
- R3: A paint command (kind 2'b01) loads each cell x with x0 <= x <= x1 with colour + (x-x0)*step. The colour word is {R[47:32], G[31:16], B[15:0]}, and each channel is unsigned with 8 integer and 8 fraction bits.
- R4: A paint leaves every cell outside [x0, x1] unchanged. A paint with x0 > x1 changes no cell.
- R5: A no-op (kind 2'b00), the unused kind 2'b11, and any word with cmd_valid low change no cell.
- R6: A refresh (kind 2'b10) sampled at edge k makes pix_valid high after edge k+x with pix_x = x and pix_data = the colour of cell x, for every x from 0 to NUM_CELLS-1. pix_valid is low in every other cycle.
- R7: A refresh returns each cell to colour zero after it has emitted the cell's colour.
- R8: When paints overlap, the one sent later sets the colour of the shared cells.
- R9: The tail carries kind, x0, x1 and step unchanged. For a paint, the tail colour is the colour advanced by step once for each cell at or right of x0. For any other kind, the tail colour is unchanged.
- R10: Refreshes are sent at least NUM_CELLS cycles apart. A paint sent in the cycle right after a refresh belongs to the next row.
- R11: The three channels wrap modulo 2^16 each, with no carry from one channel into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_kind | input | 2 | 00 no-op, 01 paint, 10 refresh, 11 unused |
| cmd_x0 | input | XW | First column of the span (XW = ceil(log2 NUM_CELLS)) |
| cmd_x1 | input | XW | Last column of the span |
| cmd_colour | input | 48 | Colour at column x0, {R,G,B} 8.8 each |
| cmd_step | input | 48 | Per-column colour increment, {R,G,B} 8.8 each |
| pix_valid | output | 1 | Pixel present |
| pix_x | output | XW | Column of the pixel |
| pix_data | output | 48 | Pixel colour |
| tail_valid | output | 1 | Command leaving the right end |
| tail_kind | output | 2 | Its kind |
| tail_x0 | output | XW | Its first column |
| tail_x1 | output | XW | Its last column |
| tail_colour | output | 48 | Its advanced colour |
| tail_step | output | 48 | Its step |

## Verification
The bench drives each command on a falling edge, so edge k is the next rising edge. From there each result has a fixed due cycle. The command acts in cell x at edge k+x and reaches the tail after edge k+NUM_CELLS-1. For a refresh, the pixel for column x is visible after edge k+x. When the bench sends a command, it queues every output that command must produce, each tagged with its due cycle. On every falling edge it then checks that each valid output is high exactly when the head of its queue is due, and compares the fields at that point. An output that is late, early, missing or extra therefore fails, and so does a wrong value.

// File: rtl/scan_pix_pkg.sv
package scan_pix_pkg;

  localparam int CH_W   = 16;   // 8 integer + 8 fraction bits
  localparam int NUM_CH = 3;
  localparam int COL_W  = NUM_CH * CH_W;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'b00,
    KIND_PAINT = 2'b01,
    KIND_FLUSH = 2'b10,
    KIND_SPARE = 2'b11
  } cmd_kind_e;

  typedef logic [COL_W-1:0] rgb_t;

  // Per-channel add, each channel wraps on its own
  function automatic rgb_t rgb_step(input rgb_t base, input rgb_t delta);
    rgb_t res;
    for (int c = 0; c < NUM_CH; c++) begin
      res[c*CH_W +: CH_W] = base[c*CH_W +: CH_W] + delta[c*CH_W +: CH_W];
    end
    return res;
  endfunction

endpackage

// File: rtl/scan_pix_cell.sv
module scan_pix_cell
  import scan_pix_pkg::*;
#(
  parameter int POS = 0,
  parameter int XW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic [XW-1:0] in_x0,
  input  logic [XW-1:0] in_x1,
  input  rgb_t          in_col,
  input  rgb_t          in_step,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [XW-1:0] out_x0,
  output logic [XW-1:0] out_x1,
  output rgb_t          out_col,
  output rgb_t          out_step,
  output rgb_t          pix,
  output logic          flush
);

  localparam logic [XW-1:0] MY_X = XW'(POS);

  logic          is_paint;
  logic [XW:0]   from_start;
  logic [XW:0]   to_end;
  logic          past_start;
  logic          before_end;
  logic          hit;

  // Sign bit of the widened difference gives the ordering
  assign from_start = {1'b0, MY_X} - {1'b0, in_x0};
  assign to_end     = {1'b0, in_x1} - {1'b0, MY_X};
  assign past_start = ~from_start[XW];
  assign before_end = ~to_end[XW];

  assign is_paint = in_valid && (in_kind == KIND_PAINT);
  assign flush    = in_valid && (in_kind == KIND_FLUSH);
  assign hit      = is_paint && past_start && before_end;

  // Pixel colour register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix <= '0;
    end else if (flush) begin
      pix <= '0;
    end else if (hit) begin
      pix <= in_col;
    end
  end

  // Hand the command to the right neighbour, colour advanced past x0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_x0    <= '0;
      out_x1    <= '0;
      out_col   <= '0;
      out_step  <= '0;
    end else begin
      out_valid <= in_valid;
      out_kind  <= in_kind;
      out_x0    <= in_x0;
      out_x1    <= in_x1;
      out_step  <= in_step;
      out_col   <= (is_paint && past_start) ? rgb_step(in_col, in_step) : in_col;
    end
  end

endmodule

// File: rtl/scan_pix_drain.sv
module scan_pix_drain
  import scan_pix_pkg::*;
#(
  parameter int N  = 16,
  parameter int XW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flush_vec,
  input  rgb_t          pix_all [N],
  output logic          pix_valid,
  output logic [XW-1:0] pix_x,
  output rgb_t          pix_data
);

  logic          sel_any;
  logic [XW-1:0] sel_x;
  rgb_t          sel_col;

  // At most one cell flushes per cycle, so an OR merge selects it
  always_comb begin
    sel_any = 1'b0;
    sel_x   = '0;
    sel_col = '0;
    for (int i = 0; i < N; i++) begin
      if (flush_vec[i]) begin
        sel_any = 1'b1;
        sel_x   = sel_x | XW'(i);
        sel_col = sel_col | pix_all[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_data  <= '0;
    end else begin
      pix_valid <= sel_any;
      pix_x     <= sel_x;
      pix_data  <= sel_col;
    end
  end

endmodule

// File: rtl/scan_pixel_array.sv
module scan_pixel_array
  import scan_pix_pkg::*;
#(
  parameter  int NUM_CELLS = 16,
  localparam int XW        = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic [XW-1:0] cmd_x0,
  input  logic [XW-1:0] cmd_x1,
  input  logic [47:0]   cmd_colour,
  input  logic [47:0]   cmd_step,
  output logic          pix_valid,
  output logic [XW-1:0] pix_x,
  output logic [47:0]   pix_data,
  output logic          tail_valid,
  output logic [1:0]    tail_kind,
  output logic [XW-1:0] tail_x0,
  output logic [XW-1:0] tail_x1,
  output logic [47:0]   tail_colour,
  output logic [47:0]   tail_step
);

  // Chain index 0 is the input port, index i+1 is the output of cell i
  logic [NUM_CELLS:0] ch_valid;
  logic [1:0]         ch_kind [NUM_CELLS+1];
  logic [XW-1:0]      ch_x0   [NUM_CELLS+1];
  logic [XW-1:0]      ch_x1   [NUM_CELLS+1];
  rgb_t               ch_col  [NUM_CELLS+1];
  rgb_t               ch_step [NUM_CELLS+1];

  // Named internal events for the checker
  logic [NUM_CELLS-1:0] flush_vec;
  rgb_t                 pix_all [NUM_CELLS];

  assign ch_valid[0] = cmd_valid;
  assign ch_kind[0]  = cmd_kind;
  assign ch_x0[0]    = cmd_x0;
  assign ch_x1[0]    = cmd_x1;
  assign ch_col[0]   = cmd_colour;
  assign ch_step[0]  = cmd_step;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    scan_pix_cell #(
      .POS (i),
      .XW  (XW)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (ch_valid[i]),
      .in_kind   (ch_kind[i]),
      .in_x0     (ch_x0[i]),
      .in_x1     (ch_x1[i]),
      .in_col    (ch_col[i]),
      .in_step   (ch_step[i]),
      .out_valid (ch_valid[i+1]),
      .out_kind  (ch_kind[i+1]),
      .out_x0    (ch_x0[i+1]),
      .out_x1    (ch_x1[i+1]),
      .out_col   (ch_col[i+1]),
      .out_step  (ch_step[i+1]),
      .pix       (pix_all[i]),
      .flush     (flush_vec[i])
    );
  end

  scan_pix_drain #(
    .N  (NUM_CELLS),
    .XW (XW)
  ) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_vec (flush_vec),
    .pix_all   (pix_all),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_data  (pix_data)
  );

  assign tail_valid  = ch_valid[NUM_CELLS];
  assign tail_kind   = ch_kind[NUM_CELLS];
  assign tail_x0     = ch_x0[NUM_CELLS];
  assign tail_x1     = ch_x1[NUM_CELLS];
  assign tail_colour = ch_col[NUM_CELLS];
  assign tail_step   = ch_step[NUM_CELLS];

endmodule

// File: rtl/scan_pix_chk.sv
module scan_pix_chk
  import scan_pix_pkg::*;
#(
  parameter int N  = 16,
  parameter int XW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  flush_vec,
  input rgb_t          pix_all [N],
  input logic [N:0]    ch_valid,
  input logic          pix_valid,
  input logic [XW-1:0] pix_x
);

  // R10
  refresh_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_vec));

  // R6
  pix_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_vec) |=> pix_valid);

  // R6
  pix_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(|flush_vec));

  // R6
  pix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |->
      (pix_x == (($past(pix_x) == XW'(N-1)) ? '0 : ($past(pix_x) + XW'(1)))));

  for (genvar i = 0; i < N; i++) begin : g_cell_chk
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vec[i] |=> (pix_all[i] == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_valid[i] |=> $stable(pix_all[i]));
  end

endmodule

bind scan_pixel_array scan_pix_chk #(
  .N  (NUM_CELLS),
  .XW (XW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_vec (flush_vec),
  .pix_all   (pix_all),
  .ch_valid  (ch_valid),
  .pix_valid (pix_valid),
  .pix_x     (pix_x)
);

// File: tb/tb_scan_pixel_array.sv
module tb_scan_pixel_array;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int XW = 4;
  localparam logic [1:0] K_NOP   = 2'b00;
  localparam logic [1:0] K_PAINT = 2'b01;
  localparam logic [1:0] K_FLUSH = 2'b10;
  localparam logic [1:0] K_SPARE = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = '0;
  logic [XW-1:0] cmd_x0 = '0;
  logic [XW-1:0] cmd_x1 = '0;
  logic [47:0]   cmd_colour = '0;
  logic [47:0]   cmd_step = '0;
  logic          pix_valid;
  logic [XW-1:0] pix_x;
  logic [47:0]   pix_data;
  logic          tail_valid;
  logic [1:0]    tail_kind;
  logic [XW-1:0] tail_x0;
  logic [XW-1:0] tail_x1;
  logic [47:0]   tail_colour;
  logic [47:0]   tail_step;

  scan_pixel_array #(.NUM_CELLS(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_x0(cmd_x0), .cmd_x1(cmd_x1),
    .cmd_colour(cmd_colour), .cmd_step(cmd_step),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_data(pix_data),
    .tail_valid(tail_valid), .tail_kind(tail_kind), .tail_x0(tail_x0), .tail_x1(tail_x1),
    .tail_colour(tail_colour), .tail_step(tail_step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int last_flush = -1000;
  bit done = 1'b0;
  bit monitor_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference row and expected-output queues
  logic [47:0]   row_m [N];
  int            pdue [$];
  logic [XW-1:0] px [$];
  logic [47:0]   pdat [$];
  int            tdue [$];
  logic [1:0]    tk [$];
  logic [XW-1:0] tx0 [$];
  logic [XW-1:0] tx1 [$];
  logic [47:0]   tc [$];
  logic [47:0]   ts [$];

  // Colour at k columns past the start, computed with a multiply per channel
  function automatic logic [47:0] col_at(input logic [47:0] base, input logic [47:0] step, input int k);
    logic [47:0] r;
    for (int c = 0; c < 3; c++) begin
      logic [31:0] prod;
      prod = 32'(step[c*16 +: 16]) * 32'(k);
      r[c*16 +: 16] = base[c*16 +: 16] + prod[15:0];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Drive one word on a falling edge and queue what it must produce
  task automatic drive(input bit v, input logic [1:0] k, input int x0, input int x1,
                       input logic [47:0] col, input logic [47:0] step);
    @(negedge clk);
    cmd_valid  = v;
    cmd_kind   = k;
    cmd_x0     = XW'(x0);
    cmd_x1     = XW'(x1);
    cmd_colour = col;
    cmd_step   = step;
    if (v) begin
      // R2 R9: tail after N-1 further edges; paint colour advanced once per cell >= x0
      tdue.push_back(cyc + N);
      tk.push_back(k);
      tx0.push_back(XW'(x0));
      tx1.push_back(XW'(x1));
      tc.push_back((k == K_PAINT) ? col_at(col, step, N - x0) : col);
      ts.push_back(step);
      if (k == K_PAINT) begin
        for (int x = x0; x <= x1; x++) row_m[x] = col_at(col, step, x - x0);
      end else if (k == K_FLUSH) begin
        for (int x = 0; x < N; x++) begin
          pdue.push_back(cyc + 1 + x);
          px.push_back(XW'(x));
          pdat.push_back(row_m[x]);
          row_m[x] = '0;
        end
        last_flush = cyc;
      end
    end
  endtask

  task automatic idle();
    drive(1'b0, K_PAINT, 0, N-1, 48'hFFFF_FFFF_FFFF, 48'h0101_0101_0101);
  endtask

  // R10: keep refreshes at least N cycles apart
  task automatic refresh();
    while (cyc - last_flush < N) idle();
    drive(1'b1, K_FLUSH, 0, 0, '0, '0);
  endtask

  task automatic paint(input int x0, input int x1, input logic [47:0] col, input logic [47:0] step);
    drive(1'b1, K_PAINT, x0, x1, col, step);
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), 16'($urandom), 16'($urandom)};
  endfunction

  // Output monitor: every output must be valid exactly on its due cycle
  always @(negedge clk) begin
    if (monitor_on && rst_n) begin
      bit pexp;
      bit texp;
      pexp = (pdue.size() > 0) && (pdue[0] == cyc);
      chk(pix_valid == pexp, "R2 R6 pixel valid timing", 64'(pix_valid), 64'(pexp));
      if (pexp) begin
        chk(pix_x == px[0], "R6 pixel column", 64'(pix_x), 64'(px[0]));
        chk(pix_data == pdat[0], "R3 R6 pixel colour", 64'(pix_data), 64'(pdat[0]));
        void'(pdue.pop_front()); void'(px.pop_front()); void'(pdat.pop_front());
      end
      texp = (tdue.size() > 0) && (tdue[0] == cyc);
      chk(tail_valid == texp, "R2 tail valid timing", 64'(tail_valid), 64'(texp));
      if (texp) begin
        chk(tail_kind == tk[0], "R9 tail kind", 64'(tail_kind), 64'(tk[0]));
        chk({tail_x0, tail_x1} == {tx0[0], tx1[0]}, "R9 tail span",
            64'({tail_x0, tail_x1}), 64'({tx0[0], tx1[0]}));
        chk(tail_colour == tc[0], "R9 tail colour", 64'(tail_colour), 64'(tc[0]));
        chk(tail_step == ts[0], "R9 tail step", 64'(tail_step), 64'(ts[0]));
        void'(tdue.pop_front()); void'(tk.pop_front()); void'(tx0.pop_front());
        void'(tx1.pop_front()); void'(tc.pop_front()); void'(ts.pop_front());
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_up();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int x = 0; x < N; x++) row_m[x] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    chk(!pix_valid, "R1 pix_valid after reset", 64'(pix_valid), 64'(0));
    chk(!tail_valid, "R1 tail_valid after reset", 64'(tail_valid), 64'(0));

    // R1 R6: refresh before any paint emits zeros
    refresh();

    // R3 R11: blue wraps past 0xFFFF without touching green
    paint(2, 9, 48'h0000_0100_FFF0, 48'h0010_0000_0008);
    refresh();

    // R7: no paint since the last refresh, so the row is black again
    refresh();

    // R4: empty span (x0 > x1), single-cell span at the right edge
    paint(10, 5, 48'h1234_5678_9ABC, 48'h0001_0001_0001);
    paint(15, 15, 48'hAA00_BB00_CC00, 48'h0100_0100_0100);
    paint(0, 0, 48'h0080_0040_0020, 48'h0000_0000_0000);
    refresh();

    // R5: no-op, unused kind and invalid word over a painted row
    paint(0, N-1, 48'h1000_2000_3000, 48'h0100_0200_0300);
    drive(1'b1, K_NOP, 0, N-1, 48'hDEAD_BEEF_0000, 48'h0001_0001_0001);
    drive(1'b1, K_SPARE, 0, N-1, 48'hFACE_CAFE_0000, 48'h0001_0001_0001);
    drive(1'b0, K_PAINT, 0, N-1, 48'h5555_5555_5555, 48'h0001_0001_0001);
    drive(1'b0, K_FLUSH, 0, 0, '0, '0);
    refresh();

    // R8: overlapping paints, the later one wins on shared cells
    paint(3, 12, 48'h0100_0100_0100, 48'h0001_0002_0003);
    paint(6, 8, 48'h7F00_0000_0000, 48'hFF00_0000_0100);
    refresh();

    // R10: paint right after the refresh lands in the next row
    paint(0, 7, 48'h0200_0300_0400, 48'h0010_0010_0010);
    refresh();
    paint(4, 11, 48'h0A00_0B00_0C00, 48'h0001_0001_0001);
    refresh();

    // Random rows of non-overlapping spans (R3 R4 R5 R9)
    for (int row = 0; row < 30; row++) begin
      int x;
      x = $urandom_range(0, 3);
      while (x < N) begin
        int x1;
        x1 = x + $urandom_range(0, 4);
        if (x1 > N-1) x1 = N-1;
        paint(x, x1, rnd48(), rnd48());
        repeat ($urandom_range(0, 2)) idle();
        if ($urandom_range(0, 3) == 0)
          drive(1'b1, ($urandom_range(0, 1) == 0) ? K_NOP : K_SPARE,
                $urandom_range(0, N-1), $urandom_range(0, N-1), rnd48(), rnd48());
        x = x1 + 1 + $urandom_range(0, 3);
      end
      refresh();
    end

    for (int w = 0; w < 4*N && (pdue.size() > 0 || tdue.size() > 0); w++) idle();
    repeat (3) idle();
    chk(pdue.size() == 0, "R6 all pixels emitted", 64'(pdue.size()), 64'(0));
    chk(tdue.size() == 0, "R2 all commands reached tail", 64'(tdue.size()), 64'(0));
    finish_up();
  end

endmodule